// File: doc/BRIEF.md
# Deep Sleep Watchdog Timer

This block is a watchdog counter that only runs while the device sits in deep sleep. When it expires, it pulses a timeout wake request to the wake-up controller. The counter's reference is one of two tick-enable inputs, both in the single system clock domain: one from the internal RC oscillator and one from the external low-frequency oscillator. A 4-bit timeout setting picks a power-of-four tick count. At a nominal 31 kHz reference, the range runs from a couple of milliseconds to several weeks.

A deep-sleep entry pulse does three things: it clears the counter, samples the timeout setting and the source select, and re-arms the timer. After that, the counter advances on each selected tick while the asleep indication and the enable bit are both high. At expiry it raises the wake output for one cycle and then freezes until the next entry.

Top module: `sleep_wdt`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `wake_tmo` is low, and no wake occurs until a deep-sleep entry has been seen.
- R2: With timeout setting n sampled at entry, `wake_tmo` rises in the cycle after the edge that consumes the 2^(6+2n)-th counted tick since that entry (setting 0 = 64 ticks, 1 = 256, 2 = 1024, 15 = 2^36).
- R3: Source select 0 counts `rc_tick` and ignores `lf_tick`. Source select 1 counts `lf_tick` and ignores `rc_tick`.
- R4: A tick counts only in a cycle where `asleep` is high. At other times the count holds its value, and counting resumes from that value.
- R5: When `wdt_en` is low, ticks do not count and no wake is produced. Raising `wdt_en` resumes counting from the held value.
- R6: A `sleep_entry` cycle clears the count to zero and re-arms the timer. A tick in that same cycle is not counted.
- R7: Changes to `tmo_sel` or `src_sel` between entries have no effect until the next `sleep_entry`.
- R8: Each expiry produces exactly one single-cycle wake pulse. No further pulse comes before the next entry, however many ticks follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wdt_en | input | 1 | Watchdog enable configuration bit |
| tmo_sel | input | 4 | Timeout setting n (2^(6+2n) ticks), sampled at entry |
| src_sel | input | 1 | Reference select, 0 = internal RC, 1 = low-frequency oscillator, sampled at entry |
| rc_tick | input | 1 | One-cycle tick from the internal RC oscillator |
| lf_tick | input | 1 | One-cycle tick from the low-frequency oscillator |
| sleep_entry | input | 1 | One-cycle pulse marking deep-sleep entry |
| asleep | input | 1 | High while the device is fully in deep sleep |
| wake_tmo | output | 1 | One-cycle timeout wake pulse |

## Verification
A count that is wrong by even one tick moves the wake pulse by a whole reference tick, so the bench compares the tick count at the moment of wake against 2^(6+2n). A stale sampled setting or source shows up as a wake at the wrong power of four, or as a wake driven by the wrong tick input, within the first expiry after entry. A stuck expiry flag shows up in one of two ways: a second pulse during the extra ticks that follow, or a missing pulse after the next entry.

// File: rtl/sleep_wdt_pkg.sv
// Shared definitions for the deep sleep watchdog.
// Assumes all tick inputs are single-cycle enables in the system clock domain.
package sleep_wdt_pkg;
    typedef enum logic {
        SRC_RC = 1'b0,
        SRC_LF = 1'b1
    } wdt_src_e;

    // Exponent of the tick count for a given timeout setting.
    function automatic int unsigned tmo_exp(input int unsigned base, input int unsigned step,
                                            input int unsigned n);
        return base + step * n;
    endfunction
endpackage

// File: rtl/sleep_wdt_cfg.sv
// Captures the source select and timeout setting on a deep-sleep entry pulse.
// Assumes the entry pulse lasts one cycle; between entries the captured values hold.
module sleep_wdt_cfg
    import sleep_wdt_pkg::*;
#(
    parameter int unsigned SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_entry,
    input  logic [SEL_W-1:0] tmo_sel,
    input  logic             src_sel,
    output logic [SEL_W-1:0] lat_sel,
    output wdt_src_e         lat_src
);
    // Sample the configuration only at entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_sel <= '0;
            lat_src <= SRC_RC;
        end else if (sleep_entry) begin
            lat_sel <= tmo_sel;
            lat_src <= wdt_src_e'(src_sel);
        end
    end
endmodule

// File: rtl/sleep_wdt_limit.sv
// Maps a timeout setting to the terminal count (2^exp - 1) and muxes the reference tick.
// Assumes CNT_W is wide enough for the largest exponent.
module sleep_wdt_limit
    import sleep_wdt_pkg::*;
#(
    parameter int unsigned SEL_W    = 4,
    parameter int unsigned BASE_EXP = 6,
    parameter int unsigned STEP_EXP = 2,
    parameter int unsigned CNT_W    = 37
) (
    input  logic [SEL_W-1:0] lat_sel,
    input  wdt_src_e         lat_src,
    input  logic             rc_tick,
    input  logic             lf_tick,
    output logic [CNT_W-1:0] term,
    output logic             ref_tick
);
    localparam int unsigned NSET = 2 ** SEL_W;

    logic [CNT_W-1:0] term_tab [NSET];

    // One terminal count per timeout setting.
    for (genvar i = 0; i < NSET; i++) begin : g_term
        assign term_tab[i] = (CNT_W'(1) << tmo_exp(BASE_EXP, STEP_EXP, i)) - CNT_W'(1);
    end

    // Select the active terminal count and reference tick.
    always_comb begin
        term     = term_tab[lat_sel];
        ref_tick = (lat_src == SRC_LF) ? lf_tick : rc_tick;
    end
endmodule

// File: rtl/sleep_wdt_core.sv
// Counts qualified reference ticks, flags expiry and emits the one-cycle wake pulse.
// Assumes term is steady between entries; entry has priority over a tick.
module sleep_wdt_core #(
    parameter int unsigned CNT_W = 37
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_entry,
    input  logic             asleep,
    input  logic             wdt_en,
    input  logic             ref_tick,
    input  logic [CNT_W-1:0] term,
    output logic [CNT_W-1:0] cnt,
    output logic             expired,
    output logic             wake_tmo
);
    logic step;

    // A tick counts only while asleep, enabled and not yet expired.
    always_comb step = asleep && wdt_en && ref_tick && !expired;

    // Counter, expiry flag and wake pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            expired  <= 1'b1;
            wake_tmo <= 1'b0;
        end else begin
            wake_tmo <= 1'b0;
            if (sleep_entry) begin
                cnt     <= '0;
                expired <= 1'b0;
            end else if (step) begin
                if (cnt == term) begin
                    expired  <= 1'b1;
                    wake_tmo <= 1'b1;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/sleep_wdt.sv
// Deep sleep watchdog top: configuration capture, limit/tick selection, counter core.
// Assumes sleep_entry is a one-cycle pulse and asleep is high while in deep sleep.
module sleep_wdt
    import sleep_wdt_pkg::*;
#(
    parameter int unsigned SEL_W    = 4,
    parameter int unsigned BASE_EXP = 6,
    parameter int unsigned STEP_EXP = 2,
    localparam int unsigned CNT_W   = BASE_EXP + STEP_EXP * (2 ** SEL_W - 1) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wdt_en,
    input  logic [SEL_W-1:0] tmo_sel,
    input  logic             src_sel,
    input  logic             rc_tick,
    input  logic             lf_tick,
    input  logic             sleep_entry,
    input  logic             asleep,
    output logic             wake_tmo
);
    logic [SEL_W-1:0] lat_sel;
    wdt_src_e         lat_src;
    logic [CNT_W-1:0] term;
    logic [CNT_W-1:0] cnt;
    logic             ref_tick;
    logic             expired;

    sleep_wdt_cfg #(.SEL_W(SEL_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .sleep_entry(sleep_entry),
        .tmo_sel(tmo_sel), .src_sel(src_sel),
        .lat_sel(lat_sel), .lat_src(lat_src)
    );

    sleep_wdt_limit #(
        .SEL_W(SEL_W), .BASE_EXP(BASE_EXP), .STEP_EXP(STEP_EXP), .CNT_W(CNT_W)
    ) u_limit (
        .lat_sel(lat_sel), .lat_src(lat_src), .rc_tick(rc_tick), .lf_tick(lf_tick),
        .term(term), .ref_tick(ref_tick)
    );

    sleep_wdt_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .sleep_entry(sleep_entry), .asleep(asleep),
        .wdt_en(wdt_en), .ref_tick(ref_tick), .term(term),
        .cnt(cnt), .expired(expired), .wake_tmo(wake_tmo)
    );
endmodule

// File: rtl/sleep_wdt_chk.sv
// Property checker for the deep sleep watchdog, bound into the top module.
// Assumes synchronous active-low reset; all properties are disabled during reset.
module sleep_wdt_chk #(
    parameter int unsigned SEL_W = 4,
    parameter int unsigned CNT_W = 37
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wdt_en,
    input logic             asleep,
    input logic             sleep_entry,
    input logic             wake_tmo,
    input logic             expired,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] term,
    input logic [SEL_W-1:0] lat_sel
);
    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_tmo |=> !wake_tmo);                                   // R8
    AST_WAKE_MEANS_EXPIRED: assert property (@(posedge clk) disable iff (!rst_n)
        wake_tmo |-> expired);                                     // R8
    AST_NO_WAKE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !wdt_en |=> !wake_tmo);                                    // R5
    AST_NO_WAKE_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !asleep |=> !wake_tmo);                                    // R4
    AST_ENTRY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_entry |=> (cnt == '0) && !expired && !wake_tmo);     // R6
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_entry |=> $stable(lat_sel));                        // R7
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= term);                                              // R2
endmodule

bind sleep_wdt sleep_wdt_chk #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wdt_en(wdt_en), .asleep(asleep),
    .sleep_entry(sleep_entry), .wake_tmo(wake_tmo), .expired(expired),
    .cnt(cnt), .term(term), .lat_sel(lat_sel)
);

// File: tb/sleep_wdt_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue the expected tick count of each wake,
// a monitor pops and compares whenever the design pulses wake_tmo.
module sleep_wdt_bench;
    typedef struct {
        longint ticks;
        string  tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wdt_en = 1'b1;
    logic [3:0] tmo_sel = '0;
    logic       src_sel = 1'b0;
    logic       rc_tick = 1'b0;
    logic       lf_tick = 1'b0;
    logic       sleep_entry = 1'b0;
    logic       asleep = 1'b0;
    logic       wake_tmo;

    int     n_chk = 0;
    int     n_bad = 0;
    int     n_wake = 0;
    exp_t   exp_q[$];
    longint bcnt = 0;
    logic   b_src = 1'b0;
    bit     done = 1'b0;

    always #2 clk = ~clk;

    sleep_wdt u_sleep_wdt (
        .clk(clk), .rst_n(rst_n), .wdt_en(wdt_en), .tmo_sel(tmo_sel),
        .src_sel(src_sel), .rc_tick(rc_tick), .lf_tick(lf_tick),
        .sleep_entry(sleep_entry), .asleep(asleep), .wake_tmo(wake_tmo)
    );

    // Reference tick count since entry, from the requirements (R3 R4 R5 R6).
    always @(posedge clk) begin
        if (!rst_n) begin
            bcnt  <= 0;
            b_src <= 1'b0;
        end else if (sleep_entry) begin
            bcnt  <= 0;
            b_src <= src_sel;
        end else if (asleep && wdt_en && (b_src ? lf_tick : rc_tick)) begin
            bcnt <= bcnt + 1;
        end
    end

    // Monitor: every wake must match the head of the expected queue (R2 R8).
    always @(negedge clk) begin : mon
        exp_t it;
        if (rst_n && wake_tmo && !done) begin
            n_wake++;
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R8 unexpected wake: actual ticks=%0d expected no wake", bcnt);
            end else begin
                it = exp_q.pop_front();
                if (bcnt != it.ticks) begin
                    n_bad++;
                    $display("FAIL %s wake tick count: actual=%0d expected=%0d",
                             it.tag, bcnt, it.ticks);
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Enter deep sleep; optionally queue the expected wake for setting sel.
    task automatic enter(input int sel, input bit src, input bit expect_wake, input string tag);
        exp_t it;
        @(posedge clk) #1;
        tmo_sel     = 4'(sel);
        src_sel     = src;
        sleep_entry = 1'b1;
        asleep      = 1'b1;
        if (expect_wake) begin
            it.ticks = longint'(1) << (6 + 2 * sel);
            it.tag   = tag;
            exp_q.push_back(it);
        end
        @(posedge clk) #1;
        sleep_entry = 1'b0;
    endtask

    // Drive n cycles of ticks: rc every cycle if rc, lf every lf_div cycles (0 = never).
    task automatic run(input int n, input bit rc, input int lf_div);
        for (int i = 0; i < n; i++) begin
            rc_tick = rc;
            lf_tick = (lf_div != 0) && (i % lf_div == 0);
            @(posedge clk) #1;
        end
        rc_tick = 1'b0;
        lf_tick = 1'b0;
    endtask

    // Confirm the queued wake arrived.
    task automatic expect_done(input string tag);
        repeat (3) @(posedge clk);
        #1;
        check(exp_q.size() == 0, {tag, " expected wake arrived"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin : wdog
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : drv
        int w0;
        repeat (3) @(posedge clk);
        #1;
        check(wake_tmo == 1'b0, "R1 wake low in reset", wake_tmo, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(wake_tmo == 1'b0, "R1 wake low after reset", wake_tmo, 0);
        // R1: no entry yet, ticks while asleep high must not wake
        asleep = 1'b1;
        run(200, 1'b1, 1);
        asleep = 1'b0;
        check(n_wake == 0, "R1 no wake before entry", n_wake, 0);

        // R2 R3: setting 0, RC source, tick every cycle
        enter(0, 1'b0, 1'b1, "R2");
        run(100, 1'b1, 0);
        expect_done("R2");

        // R3: LF source, RC noise ignored, setting 1
        enter(1, 1'b1, 1'b1, "R3");
        run(600, 1'b1, 2);
        expect_done("R3");

        // R8: keep ticking after expiry; no second pulse
        w0 = n_wake;
        run(400, 1'b0, 1);
        check(n_wake == w0, "R8 no repeat pulse", n_wake - w0, 0);

        // R2: setting 2
        enter(2, 1'b0, 1'b1, "R2 set2");
        run(1100, 1'b1, 0);
        expect_done("R2 set2");

        // R5: disabled, no wake; then enable resumes
        wdt_en = 1'b0;
        enter(0, 1'b0, 1'b0, "R5");
        w0 = n_wake;
        run(200, 1'b1, 0);
        check(n_wake == w0, "R5 no wake while disabled", n_wake - w0, 0);
        begin
            exp_t it;
            it.ticks = 64;
            it.tag   = "R5";
            exp_q.push_back(it);
        end
        wdt_en = 1'b1;
        run(100, 1'b1, 0);
        expect_done("R5");

        // R4: asleep low holds the count
        enter(0, 1'b0, 1'b1, "R4");
        run(30, 1'b1, 0);
        asleep = 1'b0;
        run(80, 1'b1, 0);
        check(n_wake == w0 + 1, "R4 no wake while awake", n_wake - w0, 1);
        asleep = 1'b1;
        run(60, 1'b1, 0);
        expect_done("R4");

        // R7: config change mid-sleep ignored
        enter(0, 1'b0, 1'b1, "R7");
        run(10, 1'b1, 0);
        tmo_sel = 4'd3;
        src_sel = 1'b1;
        run(100, 1'b1, 3);
        expect_done("R7");

        // R6: re-entry mid-count restarts from zero
        enter(1, 1'b0, 1'b0, "R6");
        run(200, 1'b1, 0);
        enter(1, 1'b0, 1'b1, "R6");
        run(300, 1'b1, 0);
        expect_done("R6");

        // R2: longest setting does not expire early
        w0 = n_wake;
        enter(15, 1'b1, 1'b0, "R2 set15");
        run(2000, 1'b0, 1);
        check(n_wake == w0, "R2 no early wake at setting 15", n_wake - w0, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule